// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from a network controller's receive path, transmit path and bus-error sources. Each event sets a sticky bit in a 26-bit status register. Software reads that register to learn what happened, and the read clears it.

A mask register chooses which status bits may raise the interrupt. A one-bit global enable gates the interrupt as a whole. One status bit is not latched: it is computed as a summary of the high-order error group. This lets a handler test a single bit before it decodes the rare error causes.

The interrupt output is a registered level. It stays high for as long as an unmasked status bit is set and the enable is on.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, `stat_o`, `mask_o`, `en_o` and `irq_o` are all zero.
- R2: A pulse on a live bit of `evt_i` sets that bit of `stat_o` from the next cycle. The bit then stays set until a status read clears it.
- R3: The live status positions are fixed, because software decodes them:
  - Bits 0 to 5 are receive events: ok, descriptor done, error, early threshold, idle, overrun.
  - Bits 6 to 10 are transmit events: ok, descriptor done, error, idle, underrun.
  - Bits 11 to 14 are counter service, software request, power event and PHY event.
  - Bit 16 is receive status FIFO overrun.
  - Bits 20 to 23 are target abort, master abort, signalled system error and parity error.
  - Bits 24 and 25 are receiver reset done and transmitter reset done.
- R4: Bits 17 to 19 always read 0, and pulses on `evt_i` at those positions have no effect. A pulse on `evt_i[15]` also has no effect.
- R5: `stat_o[15]` equals the OR of `stat_o[25:16]`, in every cycle.
- R6: While `rd_stat_i` is high, `stat_o` shows the value being read. All latched bits are zero from the next cycle, unless R7 applies.
- R7: An event that arrives in the same cycle as a status read is set in `stat_o` in the next cycle. It is not lost.
- R8: When `mask_we_i` is high, `mask_wdata_i` is loaded into `mask_o` in the next cycle. When `en_we_i` is high, `en_wdata_i` is loaded into `en_o` in the next cycle.
- R9: `irq_o` is high in cycle t+1 if and only if, in cycle t, `en_o` was 1 and `stat_o & mask_o` was nonzero.
- R10: While `en_o` is 0, `irq_o` is 0 from the next cycle, whatever the status and mask hold.
- R11: The summary bit can raise the interrupt by itself. If only mask bit 15 is set, any error-group event leads to `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 26 | Event pulses, one bit per status position |
| rd_stat_i | input | 1 | Status read strobe; clears the status at the clock edge |
| stat_o | output | 26 | Latched status with the computed summary at bit 15 |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 26 | Mask write data |
| mask_o | output | 26 | Mask register value |
| en_we_i | input | 1 | Enable write strobe |
| en_wdata_i | input | 1 | Enable write data |
| en_o | output | 1 | Global enable value |
| irq_o | output | 1 | Registered, level-sensitive interrupt request |

## Verification
The bench builds the unit with its default parameters:
- a 26-bit register;
- the summary at bit 15, over the group 16 to 25;
- live bits at 0 to 14, 16 and 20 to 25.

With these values the bench reaches every live position, the three unused holes, the summary input at 15, and a read that coincides with an event. A behavioural model tracks status, mask, enable and interrupt, and the bench compares all of them on every cycle. The stimulus includes directed sequences for each ordering and a long stretch of random events, reads and mask writes.

// File: rtl/irq_pkg.sv
package irq_pkg;
    // Default geometry of the status register.
    localparam int unsigned IRQ_W       = 26;
    localparam int unsigned IRQ_SUM_POS = 15;
    localparam int unsigned IRQ_GRP_LO  = 16;
    localparam int unsigned IRQ_GRP_HI  = 25;
    // Live (latchable) positions: 0..14, 16, 20..25.
    localparam logic [IRQ_W-1:0] IRQ_LIVE = 26'h3F1_7FFF;
endpackage

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
    parameter int unsigned       W       = irq_pkg::IRQ_W,
    parameter int unsigned       SUM_POS = irq_pkg::IRQ_SUM_POS,
    parameter int unsigned       GRP_LO  = irq_pkg::IRQ_GRP_LO,
    parameter int unsigned       GRP_HI  = irq_pkg::IRQ_GRP_HI,
    parameter logic [W-1:0]      LIVE    = irq_pkg::IRQ_LIVE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_i,
    output logic [W-1:0] view_o
);
    localparam int unsigned GRP_W = GRP_HI - GRP_LO + 1;

    typedef struct packed {
        logic [W-1:0] bits;
    } latch_t;

    latch_t st_d, st_q;
    logic [GRP_W-1:0] grp;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < int'(W); i++) begin
            if (LIVE[i]) begin
                st_d.bits[i] = (st_q.bits[i] & ~clr_i) | evt_i[i];
            end else begin
                st_d.bits[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grp = st_q.bits[GRP_HI:GRP_LO];

    always_comb begin
        view_o          = st_q.bits;
        view_o[SUM_POS] = |grp;
    end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int unsigned W = irq_pkg::IRQ_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we_i,
    input  logic [W-1:0] mask_wdata_i,
    input  logic         en_we_i,
    input  logic         en_wdata_i,
    output logic [W-1:0] mask_o,
    output logic         en_o
);
    typedef struct packed {
        logic [W-1:0] mask;
        logic         en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (mask_we_i) cfg_d.mask = mask_wdata_i;
        if (en_we_i)   cfg_d.en   = en_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask_o = cfg_q.mask;
    assign en_o   = cfg_q.en;
endmodule

// File: rtl/irq_out_drive.sv
module irq_out_drive #(
    parameter int unsigned W = irq_pkg::IRQ_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] mask_i,
    input  logic         en_i,
    output logic         irq_o
);
    typedef struct packed {
        logic req;
    } drv_t;

    drv_t drv_d, drv_q;
    logic pend;

    always_comb begin
        pend        = |(stat_i & mask_i);
        drv_d.req   = en_i & pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign irq_o = drv_q.req;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
    parameter int unsigned                 STAT_W  = irq_pkg::IRQ_W,
    parameter int unsigned                 SUM_POS = irq_pkg::IRQ_SUM_POS,
    parameter int unsigned                 GRP_LO  = irq_pkg::IRQ_GRP_LO,
    parameter int unsigned                 GRP_HI  = irq_pkg::IRQ_GRP_HI,
    parameter logic [STAT_W-1:0]           LIVE    = irq_pkg::IRQ_LIVE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_i,
    input  logic              rd_stat_i,
    output logic [STAT_W-1:0] stat_o,
    input  logic              mask_we_i,
    input  logic [STAT_W-1:0] mask_wdata_i,
    output logic [STAT_W-1:0] mask_o,
    input  logic              en_we_i,
    input  logic              en_wdata_i,
    output logic              en_o,
    output logic              irq_o
);
    logic [STAT_W-1:0] view;
    logic [STAT_W-1:0] mask;
    logic              en;

    irq_status_latch #(
        .W(STAT_W), .SUM_POS(SUM_POS), .GRP_LO(GRP_LO), .GRP_HI(GRP_HI), .LIVE(LIVE)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .clr_i  (rd_stat_i),
        .view_o (view)
    );

    irq_cfg_regs #(.W(STAT_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .en_we_i      (en_we_i),
        .en_wdata_i   (en_wdata_i),
        .mask_o       (mask),
        .en_o         (en)
    );

    irq_out_drive #(.W(STAT_W)) u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (view),
        .mask_i (mask),
        .en_i   (en),
        .irq_o  (irq_o)
    );

    assign stat_o = view;
    assign mask_o = mask;
    assign en_o   = en;
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
    parameter int unsigned STAT_W = irq_pkg::IRQ_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] evt_i,
    input logic              rd_stat_i,
    input logic [STAT_W-1:0] stat_o,
    input logic [STAT_W-1:0] mask_o,
    input logic              en_o,
    input logic              irq_o
);
    // R2: without a read, nothing already set is lost
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stat_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

    // R4: unused holes never set
    p_holes_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[17] |=> (stat_o[19:17] == 3'b000));

    // R5: an error-group event raises the summary
    p_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[20] |=> stat_o[15]);

    // R6: a quiet read empties the register
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_i && evt_i == '0) |=> (stat_o == '0));

    // R7: an event alongside a read is kept
    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_i && evt_i[0]) |=> stat_o[0]);

    // R9: pending unmasked status with enable leads to a request
    p_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && |(stat_o & mask_o)) |=> irq_o);

    // R10: no request while the enable is off
    p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |=> !irq_o);
endmodule

bind irq_status_unit irq_status_unit_chk #(.STAT_W(STAT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .rd_stat_i (rd_stat_i),
    .stat_o    (stat_o),
    .mask_o    (mask_o),
    .en_o      (en_o),
    .irq_o     (irq_o)
);

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W = 26;
    localparam logic [W-1:0] LIVE_BITS = 26'h3F1_7FFF;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt_i = '0;
    logic         rd_stat_i = 1'b0;
    logic [W-1:0] stat_o;
    logic         mask_we_i = 1'b0;
    logic [W-1:0] mask_wdata_i = '0;
    logic [W-1:0] mask_o;
    logic         en_we_i = 1'b0;
    logic         en_wdata_i = 1'b0;
    logic         en_o;
    logic         irq_o;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    finished = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_unit i_irq_status_unit (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_stat_i(rd_stat_i),
        .stat_o(stat_o), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
        .mask_o(mask_o), .en_we_i(en_we_i), .en_wdata_i(en_wdata_i),
        .en_o(en_o), .irq_o(irq_o)
    );

    // Behavioural reference
    logic [W-1:0] m_st = '0;
    logic [W-1:0] m_mask = '0;
    logic         m_en = 1'b0;
    logic         m_irq = 1'b0;

    function automatic logic [W-1:0] m_view(input logic [W-1:0] s);
        logic [W-1:0] v;
        v = s;
        v[15] = (s[25:16] != 10'd0);
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = '0; m_mask = '0; m_en = 1'b0; m_irq = 1'b0;
        end else begin
            logic [W-1:0] ns;
            m_irq = m_en && ((m_view(m_st) & m_mask) != '0);
            ns = rd_stat_i ? '0 : m_st;
            m_st = ns | (evt_i & LIVE_BITS);
            if (mask_we_i) m_mask = mask_wdata_i;
            if (en_we_i) m_en = en_wdata_i;
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            n_vec++;
            if (stat_o !== m_view(m_st)) begin
                n_bad++;
                $display("FAIL %s stat_o actual=%h expected=%h", cur_req, stat_o, m_view(m_st));
            end
            if (mask_o !== m_mask || en_o !== m_en) begin
                n_bad++;
                $display("FAIL %s cfg actual=%h/%b expected=%h/%b", cur_req, mask_o, en_o, m_mask, m_en);
            end
            if (irq_o !== m_irq) begin
                n_bad++;
                $display("FAIL %s irq_o actual=%b expected=%b", cur_req, irq_o, m_irq);
            end
        end
    end

    task automatic drive(input logic [W-1:0] ev, input logic rd,
                         input logic mw, input logic [W-1:0] md,
                         input logic ew, input logic ed);
        @(negedge clk); #1;
        evt_i = ev; rd_stat_i = rd; mask_we_i = mw; mask_wdata_i = md;
        en_we_i = ew; en_wdata_i = ed;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive('0, 0, 0, '0, 0, 0);
    endtask

    task automatic expect_irq(input logic exp, input string req);
        @(negedge clk); #2;
        n_vec++;
        if (irq_o !== exp) begin
            n_bad++;
            $display("FAIL %s directed irq actual=%b expected=%b", req, irq_o, exp);
        end
    endtask

    task automatic finish_run;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog run did not end actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        idle(3);

        cur_req = "R8";
        drive('0, 0, 1, 26'h155_AAAA, 1, 1);
        idle(2);
        drive('0, 0, 1, 26'd0, 1, 0);
        idle(2);

        cur_req = "R2";
        drive(26'h1, 0, 0, '0, 0, 0);
        idle(4);

        cur_req = "R3";
        for (int b = 0; b < W; b++) begin
            drive(26'h1 << b, 0, 0, '0, 0, 0);
            idle(1);
        end
        drive('0, 1, 0, '0, 0, 0);
        idle(2);

        cur_req = "R4";
        drive(26'h0_E8000, 0, 0, '0, 0, 0);
        idle(3);

        cur_req = "R5";
        drive(26'h040_0000, 0, 0, '0, 0, 0);
        idle(2);
        drive(26'h200_0000, 0, 0, '0, 0, 0);
        idle(2);

        cur_req = "R6";
        drive('0, 1, 0, '0, 0, 0);
        idle(2);

        cur_req = "R7";
        drive(26'h41, 0, 0, '0, 0, 0);
        drive(26'h40, 1, 0, '0, 0, 0);
        idle(3);
        drive('0, 1, 0, '0, 0, 0);
        idle(1);

        cur_req = "R9";
        drive('0, 0, 1, 26'h40, 1, 1);
        drive(26'h40, 0, 0, '0, 0, 0);
        idle(1);
        expect_irq(1'b1, "R9");
        drive('0, 1, 0, '0, 0, 0);
        idle(2);
        expect_irq(1'b0, "R9");

        cur_req = "R10";
        drive(26'h40, 0, 0, '0, 1, 0);
        idle(2);
        expect_irq(1'b0, "R10");
        drive('0, 0, 0, '0, 1, 1);
        idle(1);
        expect_irq(1'b1, "R10");
        drive('0, 1, 0, '0, 0, 0);
        idle(2);

        cur_req = "R11";
        drive('0, 0, 1, 26'h8000, 0, 0);
        drive(26'h001_0000, 0, 0, '0, 0, 0);
        idle(1);
        expect_irq(1'b1, "R11");
        drive('0, 1, 0, '0, 0, 0);
        idle(2);

        cur_req = "R2";
        for (int k = 0; k < 400; k++) begin
            logic [W-1:0] ev;
            ev = ($urandom_range(0, 3) == 0) ? (26'h1 << $urandom_range(0, W-1)) : '0;
            drive(ev, $urandom_range(0, 7) == 0,
                  $urandom_range(0, 15) == 0, W'($urandom),
                  $urandom_range(0, 31) == 0, 1'($urandom));
        end
        idle(3);

        finish_run();
    end
endmodule